// File: doc/BRIEF.md
# Minimum Response Latency Enforcer

This block sits on the response path of a memory bridge and makes every response take at least a programmed number of clock cycles. It observes request handshakes on the bridge. When a read address is accepted, it records a deadline: a free-running cycle stamp plus the read latency. When the final write-data beat is accepted, it records a deadline from the write latency in the same way. Deadlines wait in two in-order queues, one per direction. The entry at the head of each queue decides whether the matching response may pass.

Responses flow through as valid/ready streams with no data storage. While the head deadline has not been reached, the block forces the manager-side valid low and the memory-side ready low, so the memory keeps its beat in place. Once the deadline has been reached, valid and ready pass straight through in the same cycle, and ordinary back-pressure from the manager holds the beat upstream. A response that reaches the block after its deadline goes through without any added delay, and the block raises a one-cycle underrun pulse for that direction. For a read burst only the first beat is gated; the rest of the burst streams freely, and the transaction retires on its last beat.

The bridge must keep no more than `DEPTH` transactions outstanding in each direction.

Top module: `resp_latency_gate`

## Requirements
- R1: A read accepted in cycle 0 with latency L, whose first data beat is offered from cycle d (d >= 1), is first presented on `mgr_r_valid` in cycle max(L, d, 1), and never earlier.
- R2: A write whose final data beat (`w_valid & w_ready & w_last`) is accepted in cycle 0 with latency L, and whose response is offered from cycle d, is presented on `mgr_b_valid` in cycle max(L, d, 1).
- R3: A response offered after its deadline is forwarded in the same cycle it is offered, with no added delay.
- R4: While a response is being held, the manager-side valid stays low and the memory-side ready stays low.
- R5: A read burst is gated only on its first beat. Each following beat passes in the cycle it is offered, and the transaction retires on the beat with `mem_r_last` = 1.
- R6: The latency is captured when the request is accepted. Changing `rd_lat` or `wr_lat` afterwards does not change the release cycle of a transaction already queued.
- R7: If a read's deadline cycle arrives while no data is offered, `rd_underrun` pulses high for exactly one cycle, in the following cycle. It pulses once per late transaction, and never for a read that is on time.
- R8: A late write response raises `wr_underrun` under the same rule as R7, independently of the read side.
- R9: Several outstanding transactions are released in request order, each against its own deadline. With latency 4, reads accepted in cycles 0 and 1 are released in cycles 4 and 5.
- R10: After reset both queues are empty. No valid or ready is driven high toward either side, and neither underrun output is high.
- R11: When a deadline has been reached and the manager holds ready low, valid stays high toward the manager and ready stays low toward memory until the manager accepts the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_lat | input | LAT_W | Read minimum latency, in cycles |
| wr_lat | input | LAT_W | Write minimum latency, in cycles |
| ar_valid | input | 1 | Observed read address valid |
| ar_ready | input | 1 | Observed read address ready |
| w_valid | input | 1 | Observed write data valid |
| w_ready | input | 1 | Observed write data ready |
| w_last | input | 1 | Observed write data last |
| mem_r_valid | input | 1 | Read beat valid from memory |
| mem_r_ready | output | 1 | Read beat ready toward memory |
| mem_r_data | input | DATA_W | Read data from memory |
| mem_r_last | input | 1 | Last beat of the burst from memory |
| mgr_r_valid | output | 1 | Read beat valid toward the manager |
| mgr_r_ready | input | 1 | Read beat ready from the manager |
| mgr_r_data | output | DATA_W | Read data toward the manager |
| mgr_r_last | output | 1 | Last beat toward the manager |
| mem_b_valid | input | 1 | Write response valid from memory |
| mem_b_ready | output | 1 | Write response ready toward memory |
| mem_b_resp | input | RESP_W | Write response code from memory |
| mgr_b_valid | output | 1 | Write response valid toward the manager |
| mgr_b_ready | input | 1 | Write response ready from the manager |
| mgr_b_resp | output | RESP_W | Write response code toward the manager |
| rd_underrun | output | 1 | One-cycle pulse when a read deadline is missed |
| wr_underrun | output | 1 | One-cycle pulse when a write deadline is missed |

## Verification
The bench targets the release-cycle boundary cases: latency zero, a response that arrives exactly on its deadline, and one that arrives just after it. A design that compares with the wrong inequality releases one cycle early or late, and a design that counts an arrival exactly on the deadline as late raises a false underrun. The bench changes the latency while a request is queued, to catch a gate that reads the live setting instead of the captured one. It also sends bursts and back-to-back requests, to catch a gate that re-holds mid-burst beats, retires a transaction on the wrong beat, or loses the second request's deadline. A back-pressure case checks that memory ready stays low while the manager stalls, so a beat is neither dropped nor repeated.

// File: rtl/resp_gate_pkg.sv
package resp_gate_pkg;
  localparam int unsigned STAMP_W = 16;
  typedef logic [STAMP_W-1:0] stamp_t;

  // Wrap-safe test: true once now has reached or passed due.
  function automatic logic stamp_reached(input stamp_t now, input stamp_t due);
    stamp_t diff;
    diff = now - due;
    return ~diff[STAMP_W-1];
  endfunction
endpackage

// File: rtl/deadline_fifo.sv
module deadline_fifo
  import resp_gate_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  stamp_t din,
  input  logic   pop,
  output stamp_t head,
  output logic   empty,
  output logic   full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  stamp_t         slots [DEPTH];
  logic [PW-1:0]  wp, rp;
  logic [CW-1:0]  cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = slots[rp];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slots[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/gate_channel.sv
module gate_channel
  import resp_gate_pkg::*;
#(
  parameter int LAT_W = 12,
  parameter int DEPTH = 16,
  parameter bit BURST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stamp_t           now,
  input  logic             req,
  input  logic [LAT_W-1:0] lat,
  input  logic             up_valid,
  input  logic             up_last,
  output logic             up_ready,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic             underrun
);
  stamp_t head_due;
  logic   empty, full;
  logic   open_q, flagged_q, miss_q;
  logic   reached, pass_ok, fire, is_last, pop, miss;

  deadline_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req),
    .din   (now + stamp_t'(lat)),
    .pop   (pop),
    .head  (head_due),
    .empty (empty),
    .full  (full)
  );

  generate
    if (BURST) begin : g_burst
      assign is_last = up_last;
    end else begin : g_single
      assign is_last = 1'b1;
    end
  endgenerate

  assign reached  = !empty && stamp_reached(now, head_due);
  assign pass_ok  = open_q || reached;
  assign dn_valid = up_valid && pass_ok;
  assign up_ready = dn_ready && pass_ok;
  assign fire     = up_valid && dn_ready && pass_ok;
  assign pop      = fire && is_last;
  assign miss     = reached && !open_q && !up_valid && !flagged_q;
  assign underrun = miss_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      flagged_q <= 1'b0;
      miss_q    <= 1'b0;
    end else begin
      miss_q <= miss;
      if (pop)       open_q <= 1'b0;
      else if (fire) open_q <= 1'b1;
      if (pop)       flagged_q <= 1'b0;
      else if (miss) flagged_q <= 1'b1;
    end
  end

  // R4
  hold_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !dn_valid) |-> !up_ready);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  // R7
  late_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !$past(up_valid));

  // R10
  nothing_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !open_q) |-> !empty);
endmodule

// File: rtl/resp_latency_gate.sv
module resp_latency_gate
  import resp_gate_pkg::*;
#(
  parameter int LAT_W  = 12,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int RESP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAT_W-1:0]  rd_lat,
  input  logic [LAT_W-1:0]  wr_lat,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic              w_last,
  input  logic              mem_r_valid,
  output logic              mem_r_ready,
  input  logic [DATA_W-1:0] mem_r_data,
  input  logic              mem_r_last,
  output logic              mgr_r_valid,
  input  logic              mgr_r_ready,
  output logic [DATA_W-1:0] mgr_r_data,
  output logic              mgr_r_last,
  input  logic              mem_b_valid,
  output logic              mem_b_ready,
  input  logic [RESP_W-1:0] mem_b_resp,
  output logic              mgr_b_valid,
  input  logic              mgr_b_ready,
  output logic [RESP_W-1:0] mgr_b_resp,
  output logic              rd_underrun,
  output logic              wr_underrun
);
  stamp_t now_q;

  always_ff @(posedge clk) begin
    if (!rst_n) now_q <= '0;
    else        now_q <= now_q + 1'b1;
  end

  assign mgr_r_data = mem_r_data;
  assign mgr_r_last = mem_r_last;
  assign mgr_b_resp = mem_b_resp;

  gate_channel #(.LAT_W(LAT_W), .DEPTH(DEPTH), .BURST(1'b1)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .now      (now_q),
    .req      (ar_valid && ar_ready),
    .lat      (rd_lat),
    .up_valid (mem_r_valid),
    .up_last  (mem_r_last),
    .up_ready (mem_r_ready),
    .dn_valid (mgr_r_valid),
    .dn_ready (mgr_r_ready),
    .underrun (rd_underrun)
  );

  gate_channel #(.LAT_W(LAT_W), .DEPTH(DEPTH), .BURST(1'b0)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .now      (now_q),
    .req      (w_valid && w_ready && w_last),
    .lat      (wr_lat),
    .up_valid (mem_b_valid),
    .up_last  (1'b1),
    .up_ready (mem_b_ready),
    .dn_valid (mgr_b_valid),
    .dn_ready (mgr_b_ready),
    .underrun (wr_underrun)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!mgr_r_valid && !mgr_b_valid && !rd_underrun && !wr_underrun));
endmodule

// File: tb/resp_latency_gate_tb.sv
module resp_latency_gate_tb;
  localparam int LAT_W = 12, DATA_W = 32, RESP_W = 2;
  localparam int NV = 11;
  // columns: write?, latency, arrival cycle, beats, latency written after accept
  localparam int V_WR  [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 1, 0, 0};
  localparam int V_LAT [NV] = '{5, 3, 0, 6, 10, 4, 2, 0, 9, 300, 4};
  localparam int V_DLY [NV] = '{2, 7, 1, 1, 3, 1, 6, 1, 2, 5, 4};
  localparam int V_BTS [NV] = '{1, 1, 1, 4, 1, 1, 1, 1, 1, 2, 1};
  localparam int V_NEW [NV] = '{5, 3, 0, 6, 2, 4, 2, 0, 1, 300, 4};

  logic clk = 0, rst_n = 0;
  logic [LAT_W-1:0] rd_lat = '0, wr_lat = '0;
  logic ar_valid = 0, ar_ready = 0, w_valid = 0, w_ready = 0, w_last = 0;
  logic mem_r_valid = 0, mem_r_last = 0, mgr_r_ready = 1;
  logic [DATA_W-1:0] mem_r_data = '0;
  logic mem_b_valid = 0, mgr_b_ready = 1;
  logic [RESP_W-1:0] mem_b_resp = '0;
  logic mem_r_ready, mgr_r_valid, mgr_r_last, mem_b_ready, mgr_b_valid;
  logic [DATA_W-1:0] mgr_r_data;
  logic [RESP_W-1:0] mgr_b_resp;
  logic rd_underrun, wr_underrun;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  resp_latency_gate #(.LAT_W(LAT_W), .DATA_W(DATA_W), .RESP_W(RESP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_lat(rd_lat), .wr_lat(wr_lat),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .w_valid(w_valid), .w_ready(w_ready),
    .w_last(w_last), .mem_r_valid(mem_r_valid), .mem_r_ready(mem_r_ready),
    .mem_r_data(mem_r_data), .mem_r_last(mem_r_last), .mgr_r_valid(mgr_r_valid),
    .mgr_r_ready(mgr_r_ready), .mgr_r_data(mgr_r_data), .mgr_r_last(mgr_r_last),
    .mem_b_valid(mem_b_valid), .mem_b_ready(mem_b_ready), .mem_b_resp(mem_b_resp),
    .mgr_b_valid(mgr_b_valid), .mgr_b_ready(mgr_b_ready), .mgr_b_resp(mgr_b_resp),
    .rd_underrun(rd_underrun), .wr_underrun(wr_underrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  task automatic run_txn(input bit wr, input int lat, input int d, input int beats, input int newlat);
    int k, beat, urun, rel, exp_rel;
    bit done, hold_seen, hold_ok, up_v, dn_v, up_r;
    string tag;
    exp_rel = max3(lat, d, 1);
    tag = (newlat != lat) ? "R6" : ((d > lat) ? "R3" : (wr ? "R2" : "R1"));
    beat = 0; urun = 0; rel = -1; done = 0; hold_seen = 0; hold_ok = 1;
    @(negedge clk);
    if (wr) begin wr_lat = LAT_W'(lat); w_valid = 1; w_ready = 1; w_last = 1; end
    else begin rd_lat = LAT_W'(lat); ar_valid = 1; ar_ready = 1; end
    k = 1;
    while (!done && k < 6000) begin
      @(negedge clk);
      if (k == 1) begin
        ar_valid = 0; ar_ready = 0; w_valid = 0; w_ready = 0; w_last = 0;
        if (wr) wr_lat = LAT_W'(newlat); else rd_lat = LAT_W'(newlat);
      end
      up_v = (k >= d);
      if (wr) mem_b_valid = up_v;
      else begin
        mem_r_valid = up_v;
        mem_r_last  = (beats - beat == 1);
        mem_r_data  = DATA_W'(k * 7 + 1);
      end
      #1;
      dn_v = wr ? mgr_b_valid : mgr_r_valid;
      up_r = wr ? mem_b_ready : mem_r_ready;
      urun += int'(wr ? wr_underrun : rd_underrun);
      if (up_v && dn_v) begin
        if (beat == 0) rel = k;
        else check(k == rel + beat, "R5 burst beat passes", k, rel + beat);
        if (!wr && beat == beats - 1)
          check(mgr_r_last && mgr_r_data == DATA_W'(k * 7 + 1), "R5 last beat and data", int'(mgr_r_last), 1);
        beat++;
        if (beat == beats) done = 1;
      end else if (up_v) begin
        hold_seen = 1;
        if (up_r) hold_ok = 0;
      end
      k++;
    end
    check(rel == exp_rel, tag, rel, exp_rel);
    if (hold_seen) check(hold_ok, "R4 ready low while held", int'(hold_ok), 1);
    @(negedge clk);
    mem_r_valid = 0; mem_r_last = 0; mem_b_valid = 0;
    for (int i = 0; i < 3; i++) begin
      #1 urun += int'(wr ? wr_underrun : rd_underrun);
      @(negedge clk);
    end
    check(urun == ((d > max3(lat, 1, 0)) ? 1 : 0), wr ? "R8 write underrun count" : "R7 read underrun count",
          urun, (d > max3(lat, 1, 0)) ? 1 : 0);
  endtask

  initial begin
    #(5 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    mem_r_valid = 1; mem_b_valid = 1;
    #1;
    // R10 reset state: nothing passes, nothing is accepted
    check(!mgr_r_valid && !mgr_b_valid && !mem_r_ready && !mem_b_ready && !rd_underrun && !wr_underrun,
          "R10 reset quiet", int'(mgr_r_valid | mgr_b_valid | mem_r_ready | mem_b_ready), 0);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(!mgr_r_valid && !mem_r_ready && !mgr_b_valid && !mem_b_ready, "R10 empty after reset",
          int'(mgr_r_valid | mem_r_ready), 0);
    @(negedge clk);
    mem_r_valid = 0; mem_b_valid = 0;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_txn(V_WR[v] != 0, V_LAT[v], V_DLY[v], V_BTS[v], V_NEW[v]);

    // R9: two reads back to back with latency 4, data offered from cycle 2
    @(negedge clk);
    rd_lat = 12'd4; ar_valid = 1; ar_ready = 1;
    begin
      int rels [2];
      int n;
      n = 0;
      for (int k = 1; k < 12; k++) begin
        @(negedge clk);
        if (k == 2) begin ar_valid = 0; ar_ready = 0; end
        mem_r_valid = (k >= 2) && (n < 2);
        mem_r_last = 1;
        #1;
        if (mem_r_valid && mgr_r_valid) begin rels[n] = k; n++; end
      end
      check(n == 2 && rels[0] == 4, "R9 first in order", rels[0], 4);
      check(n == 2 && rels[1] == 5, "R9 second in order", rels[1], 5);
    end
    @(negedge clk);
    mem_r_valid = 0;
    repeat (3) @(negedge clk);

    // R11: deadline reached, manager stalls until cycle 6
    rd_lat = 12'd3; ar_valid = 1; ar_ready = 1; mgr_r_ready = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      ar_valid = 0; ar_ready = 0;
      mem_r_valid = 1; mem_r_last = 1;
      if (k == 6) mgr_r_ready = 1;
      #1;
      if (k == 4) check(mgr_r_valid && !mem_r_ready, "R11 stalled beat kept", int'(mem_r_ready), 0);
      if (k == 6) check(mgr_r_valid && mem_r_ready, "R11 accepted after stall", int'(mem_r_ready), 1);
    end
    @(negedge clk);
    mem_r_valid = 0;
    #1;
    check(!mgr_r_valid, "R11 no duplicate beat", int'(mgr_r_valid), 0);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule